// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial byte memory. It samples the clock and data lines of the bus on its own system clock and detects bus start and stop events. It shifts in a control byte, checks the fixed device-type nibble and the device-select bits against hard-wired select pins, and acknowledges by pulling the data line low. After the control byte it either takes a word address and one data byte for a byte write, or it returns the byte at its address pointer for a read.

The memory size is a parameter. Depending on that size, the three control-byte bits below the device-type nibble are split between chip-select bits and upper memory-block address bits. Block bits become the top bits of the word address. A byte write is committed only after the closing stop, when a programming interval of a parameterised number of system clocks has run. During that interval the block refuses every control byte.

The data output is open-drain: the block only ever asserts a pull-low request. The system-level pad or the bench resolves the wired line.

Top module: `twi_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Until a start is seen, bits clocked on the bus are ignored and never acknowledged.
- R2: The first byte after a start is the control byte, sent MSB first. It is acknowledged only if bits 7:4 equal 4'b1010. Bit 0 selects a read (1) or a write (0).
- R3: Control bits 3:1 are split by size. Up to 256 bytes, all three must equal `sel_pins_i[2:0]`. At 512 bytes, bit 1 is block bit 0 and bits 3:2 must equal `sel_pins_i[2:1]`. At 1 KB, bits 2:1 are block bits and bit 3 must equal `sel_pins_i[2]`. At 2 KB, no pin is compared. Unused select pins have no effect.
- R4: `sda_pull_o` is 0 out of reset. It goes to 1 after an SCL fall and holds through the ninth clock pulse to acknowledge a matching control byte, the word address and the data byte. It is released after the falling edge that ends that pulse.
- R5: In a write, the word address is {control block bits, address byte}, truncated to the memory size. With 512 bytes, control bit 1 is word-address bit 8.
- R6: The stop that follows an acknowledged data byte starts a programming interval of PROG_CYCLES system clocks, and the byte is stored when the interval ends. A stop or start before the data byte is complete stores nothing and starts no interval.
- R7: While the programming interval runs, no control byte is acknowledged.
- R8: A read returns the byte at the address pointer, MSB first, one bit per SCL pulse. The pointer then increments, wrapping from MEM_BYTES-1 to 0. A repeated start after the word address turns a write into a random read.
- R9: During the master's acknowledge bit after a read byte, the data line is released. After that bit and a stop, the block is idle and answers the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Resolved bus data line (asynchronous) |
| sel_pins_i | input | 3 | Hard-wired device-select pins |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain) |

## Verification
A table of byte writes over both memory blocks, with addresses at 0, mid-range and the top of each block, is written and then read back by random read. This separates a block bit that reaches the address from one that is dropped, because the same address byte in the two blocks must hold different data. Control bytes with a wrong nibble, a wrong compared pin and a flipped uncompared pin separate correct select decoding from over-strict or over-loose decoding. A control byte sent during programming, a data byte cut off by a stop, and current-address reads at the end of each block separate the busy gating, the commit rule and the wrapping pointer.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_HOLD,
    ST_RD,
    ST_RD_ACK
  } twi_st_e;

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // data edges while clock stays high are bus conditions, never data
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned PROG_CYCLES = 1000,
  localparam int unsigned ADDR_W     = $clog2(MEM_BYTES),
  localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);

  logic [7:0]        mem [MEM_BYTES];
  logic [CNT_W-1:0]  prog_cnt;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data;
  logic              commit;

  assign commit = (prog_cnt == CNT_W'(1));
  assign busy_o = (prog_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_cnt  <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (prog_start_i) begin
      prog_cnt  <= CNT_W'(PROG_CYCLES);
      pend_addr <= wr_addr_i;
      pend_data <= wr_data_i;
    end else if (busy_o) begin
      prog_cnt <= prog_cnt - CNT_W'(1);
    end
  end

  // byte lands only at the end of the programming interval
  always_ff @(posedge clk_i) begin
    if (commit) mem[pend_addr] <= pend_data;
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/twi_mem_fsm.sv
module twi_mem_fsm
  import twi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned BLK_BITS = 1,
  localparam logic [2:0] PIN_MASK = 3'(3'b111 << BLK_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        sel_pins_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_start_o,
  output logic              pull_o,
  output twi_st_e           st_o
);

  twi_st_e           st;
  logic [3:0]        bit_cnt;
  logic [7:0]        sh, ctrl_q, tx;
  logic [ADDR_W-1:0] ptr;
  logic              pend, drive, ctrl_ok, byte_in;

  assign ctrl_ok = (sh[7:4] == DEV_TYPE) &&
                   (((sh[3:1] ^ sel_pins_i) & PIN_MASK) == 3'b000) &&
                   !busy_i;
  assign byte_in = (bit_cnt == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      ctrl_q    <= '0;
      tx        <= '0;
      ptr       <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      pend      <= 1'b0;
      drive     <= 1'b0;
    end else if (start_i) begin
      st      <= ST_CTRL;
      bit_cnt <= '0;
      pend    <= 1'b0;
      drive   <= 1'b0;
    end else if (stop_i) begin
      st    <= ST_IDLE;
      pend  <= 1'b0;
      drive <= 1'b0;
    end else begin
      unique case (st)
        ST_CTRL, ST_ADDR, ST_DATA: begin
          if (scl_rise_i && !byte_in) begin
            sh      <= {sh[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (scl_fall_i && byte_in) begin
            bit_cnt <= '0;
            if (st == ST_CTRL) begin
              if (ctrl_ok) begin
                ctrl_q <= sh;
                drive  <= 1'b1;
                st     <= ST_CTRL_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_ADDR) begin
              // block bits sit directly above the address byte
              ptr   <= ADDR_W'({ctrl_q[3:1], sh});
              drive <= 1'b1;
              st    <= ST_ADDR_ACK;
            end else begin
              wr_addr_o <= ptr;
              wr_data_o <= sh;
              pend      <= 1'b1;
              drive     <= 1'b1;
              st        <= ST_DATA_ACK;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (ctrl_q[0]) begin
              tx      <= {rd_data_i[6:0], 1'b0};
              drive   <= ~rd_data_i[7];
              bit_cnt <= 4'd1;
              ptr     <= ptr + ADDR_W'(1);
              st      <= ST_RD;
            end else begin
              drive <= 1'b0;
              st    <= ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            drive <= 1'b0;
            st    <= ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (scl_fall_i) begin
            drive <= 1'b0;
            st    <= ST_HOLD;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (byte_in) begin
              drive <= 1'b0;
              st    <= ST_RD_ACK;
            end else begin
              drive   <= ~tx[7];
              tx      <= {tx[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          // master ack or nack: single-byte reads only
          if (scl_rise_i) st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign prog_start_o = stop_i && pend;
  assign rd_addr_o    = ptr;
  assign pull_o       = drive;
  assign st_o         = st;

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned PROG_CYCLES = 1000,
  localparam int unsigned ADDR_W     = $clog2(MEM_BYTES),
  localparam int unsigned BLK_BITS   = (ADDR_W > 8) ? ADDR_W - 8 : 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_pins_i,
  output logic       sda_pull_o
);

  logic              sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic              busy_w, prog_start_w;
  logic [7:0]        rd_data_w, wr_data_w;
  logic [ADDR_W-1:0] rd_addr_w, wr_addr_w;
  twi_st_e           fsm_st;

  twi_bus_sync #(.STAGES(2)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  twi_mem_fsm #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_w),
    .scl_rise_i   (scl_rise_w),
    .scl_fall_i   (scl_fall_w),
    .start_i      (start_w),
    .stop_i       (stop_w),
    .sel_pins_i   (sel_pins_i),
    .busy_i       (busy_w),
    .rd_data_i    (rd_data_w),
    .rd_addr_o    (rd_addr_w),
    .wr_addr_o    (wr_addr_w),
    .wr_data_o    (wr_data_w),
    .prog_start_o (prog_start_w),
    .pull_o       (sda_pull_o),
    .st_o         (fsm_st)
  );

  twi_mem_array #(.MEM_BYTES(MEM_BYTES), .PROG_CYCLES(PROG_CYCLES)) i_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_w),
    .wr_addr_i    (wr_addr_w),
    .wr_data_i    (wr_data_w),
    .rd_addr_i    (rd_addr_w),
    .rd_data_o    (rd_data_w),
    .busy_o       (busy_w)
  );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    pull_i,
  input logic    busy_i,
  input logic    prog_start_i,
  input logic    scl_fall_i,
  input logic    start_i,
  input logic    stop_i,
  input twi_st_e st_i
);

  a_r4_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !pull_i);

  a_r4_pull_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_i) |-> $past(scl_fall_i));

  a_r4_release_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_i) |-> $past(scl_fall_i || start_i || stop_i));

  a_r6_stop_starts_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_i |=> busy_i);

  a_r6_busy_only_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(prog_start_i));

  a_r7_no_ack_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (st_i != ST_CTRL_ACK));

endmodule

bind twi_mem_slave twi_mem_slave_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pull_i       (sda_pull_o),
  .busy_i       (busy_w),
  .prog_start_i (prog_start_w),
  .scl_fall_i   (scl_fall_w),
  .start_i      (start_w),
  .stop_i       (stop_w),
  .st_i         (fsm_st)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] sel = 3'b101;
  logic pull;
  logic sda_line;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~pull;

  twi_mem_slave i_twi_mem_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sel_pins_i (sel),
    .sda_pull_o (pull)
  );

  // control byte for select pins 3'b101 at 512 bytes: 1010_1_0_blk_rw
  function automatic logic [7:0] ctrl(input logic blk, input logic rw);
    return {7'b1010_10_0, rw} | {6'b0, blk, 1'b0};
  endfunction

  // {block bit, address byte, data byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h00, 8'h3C},
    {1'b1, 8'h00, 8'hC3},
    {1'b0, 8'h7F, 8'h01},
    {1'b1, 8'hFF, 8'hA5},
    {1'b0, 8'hFF, 8'h5A},
    {1'b1, 8'h10, 8'hFE}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic qw;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; qw;
    m_scl = 1'b1; qw;
    m_sda = 1'b0; qw;
    m_scl = 1'b0; qw;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qw;
    m_scl = 1'b1; qw;
    m_sda = 1'b1; qw;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qw;
      m_scl = 1'b1; qw; qw;
      m_scl = 1'b0; qw;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    m_sda = 1'b1; qw;
    m_scl = 1'b1; qw;
    acked = !sda_line; qw;
    m_scl = 1'b0; qw;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b, output logic released);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw;
      m_scl = 1'b1; qw;
      b[i] = sda_line; qw;
      m_scl = 1'b0;
    end
    qw;
    m_sda = !master_ack; qw;
    m_scl = 1'b1; qw;
    released = sda_line; qw;
    m_scl = 1'b0; qw;
  endtask

  task automatic write_byte(input logic blk, input logic [7:0] a, input logic [7:0] d,
                            output logic [2:0] acks);
    logic k;
    bus_start;
    send_byte(ctrl(blk, 1'b0), k); acks[2] = k;
    send_byte(a, k);               acks[1] = k;
    send_byte(d, k);               acks[0] = k;
    bus_stop;
  endtask

  task automatic rand_read(input logic blk, input logic [7:0] a, output logic [7:0] d);
    logic k, rel;
    bus_start;
    send_byte(ctrl(blk, 1'b0), k);
    send_byte(a, k);
    bus_start;
    send_byte(ctrl(blk, 1'b1), k);
    recv_byte(1'b0, d, rel);
    bus_stop;
  endtask

  task automatic cur_read(output logic [7:0] d, output logic rel);
    logic k;
    bus_start;
    send_byte(ctrl(1'b0, 1'b1), k);
    recv_byte(1'b0, d, rel);
    bus_stop;
  endtask

  task automatic wait_prog;
    repeat (1100) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic k, rel;

    repeat (3) @(negedge clk);
    chk("R4 reset release", {7'b0, pull}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: a byte clocked with no start is ignored
    send_byte(ctrl(1'b0, 1'b0), k);
    chk("R1 no start no ack", {7'b0, k}, 8'h00);
    bus_stop;

    // table: write each vector, wait out programming, read it back
    for (int v = 0; v < 6; v++) begin
      write_byte(VEC[v][16], VEC[v][15:8], VEC[v][7:0], acks);
      chk("R4 write acks", {5'b0, acks}, 8'h07);
      wait_prog;
      rand_read(VEC[v][16], VEC[v][15:8], d);
      chk("R6 R8 readback", d, VEC[v][7:0]);
    end

    // R5: block bit separates the two blocks
    rand_read(1'b0, 8'h00, d);
    chk("R5 block 0 kept", d, 8'h3C);

    // R2: wrong device-type nibble
    bus_start;
    send_byte(8'hB8, k);
    chk("R2 bad nibble", {7'b0, k}, 8'h00);
    bus_stop;

    // R3: compared pin mismatch
    bus_start;
    send_byte(8'hA4, k);
    chk("R3 pin mismatch", {7'b0, k}, 8'h00);
    bus_stop;

    // R3: uncompared pin has no effect
    sel = 3'b100;
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k);
    chk("R3 unused pin ignored", {7'b0, k}, 8'h01);
    bus_stop;
    sel = 3'b101;

    // R7: control byte during programming refused
    write_byte(1'b0, 8'h20, 8'h77, acks);
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k);
    chk("R7 busy no ack", {7'b0, k}, 8'h00);
    bus_stop;
    wait_prog;
    rand_read(1'b0, 8'h20, d);
    chk("R6 commit after interval", d, 8'h77);

    // R6: stop mid data byte stores nothing, no busy interval
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k);
    send_byte(8'h7F, k);
    send_bits(8'hF0, 4);
    bus_stop;
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k);
    chk("R6 no interval after cut", {7'b0, k}, 8'h01);
    bus_stop;
    rand_read(1'b0, 8'h7F, d);
    chk("R6 cut byte not stored", d, 8'h01);

    // R8: pointer increments across block boundary
    rand_read(1'b0, 8'hFF, d);
    chk("R8 read 0x0FF", d, 8'h5A);
    cur_read(d, rel);
    chk("R8 increment to 0x100", d, 8'hC3);

    // R8: pointer wraps from top to 0
    rand_read(1'b1, 8'hFF, d);
    chk("R8 read 0x1FF", d, 8'hA5);
    bus_start;
    send_byte(ctrl(1'b0, 1'b1), k);
    recv_byte(1'b0, d, rel);
    chk("R9 line released on master ack", {7'b0, rel}, 8'h01);
    bus_stop;
    chk("R8 wrap to 0", d, 8'h3C);
    chk("R9 idle after stop", {7'b0, pull}, 8'h00);

    // R9: fresh transaction answered after read end
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k);
    chk("R9 answers next start", {7'b0, k}, 8'h01);
    bus_stop;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule